// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a synchronous static RAM whose data bus never needs an idle cycle when it turns from reading to writing or back. Address, control and write data are all captured on the rising clock edge. A read returns its word two enabled clocks after its address is taken. A write takes its data two enabled clocks after its address. Because both slots sit at the same distance, one operation can be issued on every clock whatever the mix.

Write data is not put into the array when it arrives. It is parked in a one-entry pending-write buffer and copied into the array only when the next write's data comes in. A read that hits the parked address gets the parked bytes merged over the array word. A small burst controller either loads a fresh address or steps a 2-bit counter from the last loaded address, in linear or interleaved order. Its state machine has three states. ST_IDLE means no active burst. ST_RD_BURST means a read burst is active, and ST_WR_BURST means a write burst is active. Every load cycle moves the machine to one of the three states: ST_IDLE when the chip enables do not all agree, otherwise ST_WR_BURST or ST_RD_BURST according to `we`. Every advance cycle keeps the current state.

The array holds `MEM_WORDS` words. Address bits above the array index are ignored, so addresses alias modulo `MEM_WORDS`.

Top module: `nws_sram`

## Requirements
- R1: A read accepted at rising edge k puts its word on `rdata` with `rdata_oe` high after enabled edge k+2, counting only edges where `clk_en` is high.
- R2: The data of a write accepted at edge k is sampled from `wdata` at enabled edge k+2. Lane bit l of `lane_we` covers `wdata` bits 9l+8 down to 9l. Lanes whose bit is low keep their stored value.
- R3: Reads and writes may alternate on every clock. A read issued in the cycle after a write to the same address returns the new merged data.
- R4: With `burst_ilv` low on the load cycle, each advance cycle (`adv_ld` high) steps the low two address bits as start+1, start+2, start+3, wrapping modulo 4. The upper bits stay those of the loaded address.
- R5: With `burst_ilv` high on the load cycle, the low two address bits on the n-th advance are the start bits XOR n, for n = 1, 2, 3.
- R6: A load cycle (`adv_ld` low) is accepted only when `cs_a` is high, `cs_b` is high and `cs_n` is low. Otherwise it is a deselect: nothing is written and `rdata_oe` stays low in its data slot.
- R7: While `clk_en` is low, no state changes. `rdata` and `rdata_oe` hold, and inputs in that cycle are ignored.
- R8: `rdata_oe` is high only in read data slots. In every other slot it is low and `rdata` is zero.
- R9: After reset, `rdata_oe` is low, `rdata` is zero and no burst is active.
- R10: Advance cycles take the operation type and lane enables from the last load cycle. Their own `we` and `lane_we` values are ignored. An advance after a deselect stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; low freezes the block |
| cs_a | input | 1 | Chip enable, active high |
| cs_b | input | 1 | Chip enable, active high |
| cs_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 1 = advance the burst, 0 = load a new address |
| we | input | 1 | 1 = write, 0 = read (load cycles only) |
| burst_ilv | input | 1 | 1 = interleaved order, 0 = linear order (load cycles only) |
| lane_we | input | LANES (4) | Per-lane write enables (load cycles only) |
| addr | input | ADDR_W (18) | Word address |
| wdata | input | DATA_W (36) | Write data, sampled two enabled clocks after its address |
| rdata | output | DATA_W (36) | Read data |
| rdata_oe | output | 1 | Drive enable for the shared data bus |

## Verification
The hardest case to reach is a read whose word still sits only in the pending-write buffer, in particular with a partial lane mask merged over older array contents. The stimulus gets there by writing a full word, then issuing a masked write to the same address and reading that address in the very next cycle. At that point the masked data has been parked but no later write has pushed it into the array. A reference memory in the bench applies each write at its data slot and predicts every read slot, including stalls and bursts.

// File: rtl/nws_pkg.sv
package nws_pkg;

    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_BURST = 2'd1,
        ST_WR_BURST = 2'd2
    } burst_st_e;

    // low two address bits for the n-th word of a burst
    function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                                input logic [1:0] n,
                                                input logic       ilv);
        burst_offset = ilv ? (start ^ n) : (start + n);
    endfunction

endpackage

// File: rtl/nws_burst_ctl.sv
module nws_burst_ctl
    import nws_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              adv_i,
    input  logic              wr_i,
    input  logic              sel_ok_i,
    input  logic              ilv_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              op_valid_o,
    output logic              op_wr_o,
    output logic [ADDR_W-1:0] op_addr_o,
    output logic [LANES-1:0]  op_be_o
);

    burst_st_e         st_q, st_d, load_tgt;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q, cnt_d;
    logic              ilv_q;
    logic [LANES-1:0]  be_q;

    // next-state logic
    always_comb begin
        if (!sel_ok_i)  load_tgt = ST_IDLE;
        else if (wr_i)  load_tgt = ST_WR_BURST;
        else            load_tgt = ST_RD_BURST;

        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (!adv_i) st_d = load_tgt;
            ST_RD_BURST: if (!adv_i) st_d = load_tgt;
            ST_WR_BURST: if (!adv_i) st_d = load_tgt;
            default:     st_d = ST_IDLE;
        endcase
        cnt_d = adv_i ? (cnt_q + 2'd1) : 2'd0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= 2'd0;
            base_q <= '0;
            ilv_q  <= 1'b0;
            be_q   <= '0;
        end else if (clk_en) begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (!adv_i) begin
                base_q <= addr_i;
                ilv_q  <= ilv_i;
                be_q   <= be_i;
            end
        end
    end

    // issued operation for this cycle
    always_comb begin
        op_valid_o = (st_d != ST_IDLE);
        op_wr_o    = (st_d == ST_WR_BURST);
        if (adv_i) begin
            op_addr_o = {base_q[ADDR_W-1:2], burst_offset(base_q[1:0], cnt_d, ilv_q)};
            op_be_o   = be_q;
        end else begin
            op_addr_o = addr_i;
            op_be_o   = be_i;
        end
    end

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_i && !sel_ok_i) |=> (st_q == ST_IDLE)) else $error("deselect load"); // R6
    AST_ADV_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_i) |=> (st_q == $past(st_q))) else $error("advance changed op"); // R10
    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_i) |=> (cnt_q == 2'd0)) else $error("burst count not restarted"); // R4

endmodule

// File: rtl/nws_late_write.sv
module nws_late_write
    import nws_pkg::*;
#(
    parameter int DATA_W    = 36,
    parameter int MEM_WORDS = 256,
    localparam int LANES    = DATA_W / LANE_W,
    localparam int IDX_W    = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              wr_slot_i,
    input  logic [IDX_W-1:0]  slot_idx_i,
    input  logic [LANES-1:0]  slot_be_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rd_word_o
);

    logic [DATA_W-1:0] mem [MEM_WORDS];
    logic              pend_v;
    logic [IDX_W-1:0]  pend_idx;
    logic [LANES-1:0]  pend_be;
    logic [DATA_W-1:0] pend_data;
    logic              hit;

    // pending entry: replaced on every write data slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_idx  <= '0;
            pend_be   <= '0;
            pend_data <= '0;
        end else if (clk_en && wr_slot_i) begin
            pend_v    <= 1'b1;
            pend_idx  <= slot_idx_i;
            pend_be   <= slot_be_i;
            pend_data <= wdata_i;
        end
    end

    // commit the older pending entry into the array
    always_ff @(posedge clk) begin
        if (clk_en && wr_slot_i && pend_v) begin
            for (int l = 0; l < LANES; l++) begin
                if (pend_be[l]) mem[pend_idx][l*LANE_W +: LANE_W] <= pend_data[l*LANE_W +: LANE_W];
            end
        end
    end

    assign hit = pend_v && (pend_idx == slot_idx_i);

    // bypass merge per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_word_o[g*LANE_W +: LANE_W] = (hit && pend_be[g])
            ? pend_data[g*LANE_W +: LANE_W]
            : mem[slot_idx_i][g*LANE_W +: LANE_W];
    end

    AST_PEND_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && wr_slot_i) |=> pend_v) else $error("pending entry not filled"); // R2
    AST_PEND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(pend_v) && $stable(pend_idx) && $stable(pend_data))) else $error("pending moved in stall"); // R7

endmodule

// File: rtl/nws_sram.sv
module nws_sram
    import nws_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 36,
    parameter int MEM_WORDS = 256,
    localparam int LANES    = DATA_W / LANE_W,
    localparam int IDX_W    = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              cs_a,
    input  logic              cs_b,
    input  logic              cs_n,
    input  logic              adv_ld,
    input  logic              we,
    input  logic              burst_ilv,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    logic              sel_ok;
    logic              op_v, op_wr;
    logic [ADDR_W-1:0] op_addr;
    logic [LANES-1:0]  op_be;

    logic              s1_v, s1_wr, s2_v, s2_wr;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [LANES-1:0]  s1_be, s2_be;
    logic              rd_slot, wr_slot;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;
    logic              oe_q;

    assign sel_ok = cs_a & cs_b & ~cs_n;

    nws_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .adv_i      (adv_ld),
        .wr_i       (we),
        .sel_ok_i   (sel_ok),
        .ilv_i      (burst_ilv),
        .be_i       (lane_we),
        .addr_i     (addr),
        .op_valid_o (op_v),
        .op_wr_o    (op_wr),
        .op_addr_o  (op_addr),
        .op_be_o    (op_be)
    );

    // two-stage control pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v <= 1'b0; s1_wr <= 1'b0; s1_addr <= '0; s1_be <= '0;
            s2_v <= 1'b0; s2_wr <= 1'b0; s2_addr <= '0; s2_be <= '0;
        end else if (clk_en) begin
            s1_v <= op_v;  s1_wr <= op_wr;  s1_addr <= op_addr; s1_be <= op_be;
            s2_v <= s1_v;  s2_wr <= s1_wr;  s2_addr <= s1_addr; s2_be <= s1_be;
        end
    end

    assign rd_slot = s2_v & ~s2_wr;
    assign wr_slot = s2_v &  s2_wr;

    if (IDX_W < ADDR_W) begin : g_alias
        logic unused_hi;
        assign unused_hi = ^s2_addr[ADDR_W-1:IDX_W];
    end

    nws_late_write #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .wr_slot_i  (wr_slot),
        .slot_idx_i (s2_addr[IDX_W-1:0]),
        .slot_be_i  (s2_be),
        .wdata_i    (wdata),
        .rd_word_o  (rd_word)
    );

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q    <= 1'b0;
            rdata_q <= '0;
        end else if (clk_en) begin
            oe_q    <= rd_slot;
            rdata_q <= rd_slot ? rd_word : '0;
        end
    end

    assign rdata    = rdata_q;
    assign rdata_oe = oe_q;

    AST_RD_SLOT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s2_v && !s2_wr) |=> rdata_oe) else $error("read slot not driven"); // R1
    AST_NO_STRAY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !(s2_v && !s2_wr)) |=> (!rdata_oe && rdata == '0)) else $error("bus driven outside read"); // R8
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(rdata) && $stable(rdata_oe) && $stable(s1_v) && $stable(s2_v))) else $error("stall moved state"); // R7

endmodule

// File: tb/tb_nws_sram.sv
`timescale 1ns/1ps
module tb_nws_sram;

    localparam int AW = 18;
    localparam int DW = 36;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          cs_a = 1'b0, cs_b = 1'b0, cs_n = 1'b1;
    logic          adv_ld = 1'b0, we = 1'b0, burst_ilv = 1'b0;
    logic [NL-1:0] lane_we = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    always #10 clk = ~clk;

    nws_sram dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .cs_a(cs_a), .cs_b(cs_b), .cs_n(cs_n),
        .adv_ld(adv_ld), .we(we), .burst_ilv(burst_ilv),
        .lane_we(lane_we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    logic [DW-1:0] refm [0:255];
    logic          h_v [2], h_wr [2];
    logic [AW-1:0] h_ad [2];
    logic [NL-1:0] h_be [2];
    logic          exp_oe = 1'b0;
    logic [DW-1:0] exp_d = '0;
    logic          m_act = 1'b0, m_wr = 1'b0, m_il = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = 2'd0;
    logic [NL-1:0] m_be = '0;
    int            gseq = 0;

    typedef struct packed {
        logic          adv; logic w; logic a1; logic b1; logic cn; logic il;
        logic [3:0]    be;
        logic [17:0]   a;
    } vec_t;

    localparam vec_t TBL [0:9] = '{
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF, 18'h10},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF, 18'h11},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 18'h10},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 18'h11},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'h1, 18'h10},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 18'h10},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 18'h00},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 18'h00},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 18'h00},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 18'h00}
    };

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit adv, input bit w, input bit a1, input bit b1,
                        input bit cn, input bit il, input logic [3:0] be, input logic [AW-1:0] a);
        logic [DW-1:0] wd;
        logic [AW-1:0] eff;
        @(negedge clk);
        chk("R8", "oe", {35'd0, rdata_oe}, {35'd0, exp_oe});
        chk(tag, "rdata", rdata, exp_d);
        // data slot of the operation issued two cycles ago
        gseq++;
        wd = (DW'(gseq) * 36'h0_1234_5679) ^ 36'hA_5A5A_5A5A;
        if (h_v[1] && h_wr[1]) begin
            for (int l = 0; l < NL; l++)
                if (h_be[1][l]) refm[h_ad[1][7:0]][l*9 +: 9] = wd[l*9 +: 9];
        end
        if (h_v[1] && !h_wr[1]) begin
            exp_oe = 1'b1; exp_d = refm[h_ad[1][7:0]];
        end else begin
            exp_oe = 1'b0; exp_d = '0;
        end
        // burst model
        if (!adv) begin
            m_act = a1 && b1 && !cn; m_wr = w; m_il = il; m_base = a; m_cnt = 2'd0; m_be = be;
            eff = a;
        end else begin
            m_cnt = m_cnt + 2'd1;
            eff = {m_base[AW-1:2], m_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
        end
        h_v[1] = h_v[0]; h_wr[1] = h_wr[0]; h_ad[1] = h_ad[0]; h_be[1] = h_be[0];
        h_v[0] = m_act;  h_wr[0] = m_wr;    h_ad[0] = eff;     h_be[0] = m_be;
        clk_en = 1'b1; adv_ld = adv; we = w; cs_a = a1; cs_b = b1; cs_n = cn;
        burst_ilv = il; lane_we = be; addr = a; wdata = wd;
    endtask

    task automatic ld(input string tag, input bit w, input logic [3:0] be, input logic [AW-1:0] a, input bit il);
        step(tag, 1'b0, w, 1'b1, 1'b1, 1'b0, il, be, a);
    endtask
    task automatic adv(input string tag, input bit w, input logic [3:0] be);
        step(tag, 1'b1, w, 1'b0, 1'b0, 1'b1, 1'b0, be, 18'h3FFFF);
    endtask
    task automatic nop(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, '0);
    endtask

    task automatic stall(input int n);
        logic          sv_oe;
        logic [DW-1:0] sv_d;
        @(negedge clk);
        sv_oe = rdata_oe; sv_d = rdata;
        clk_en = 1'b0; adv_ld = 1'b0; we = 1'b1; cs_a = 1'b1; cs_b = 1'b1; cs_n = 1'b0;
        lane_we = 4'hF; addr = 18'h20; wdata = 36'hF_FFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R7", "held oe", {35'd0, rdata_oe}, {35'd0, sv_oe});
            chk("R7", "held rdata", rdata, sv_d);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin h_v[i] = 0; h_wr[i] = 0; h_ad[i] = '0; h_be[i] = '0; end
        for (int i = 0; i < 256; i++) refm[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset oe", {35'd0, rdata_oe}, 36'd0);
        chk("R9", "reset rdata", rdata, '0);

        // table walk: writes, reads, bypass and deselect flush
        for (int i = 0; i < 10; i++)
            step("R1", TBL[i].adv, TBL[i].w, TBL[i].a1, TBL[i].b1, TBL[i].cn, TBL[i].il, TBL[i].be, TBL[i].a);
        nop("R1", 3);

        // R3: strict write/read alternation with partial rewrite
        ld("R3", 1, 4'hF, 18'h40, 0); ld("R3", 0, 4'h0, 18'h40, 0);
        ld("R3", 1, 4'hF, 18'h41, 0); ld("R3", 0, 4'h0, 18'h41, 0);
        ld("R3", 1, 4'b0110, 18'h40, 0); ld("R3", 0, 4'h0, 18'h40, 0);
        nop("R3", 3);

        // R2: lane mask keeps unselected lanes, read after array commit
        ld("R2", 1, 4'hF, 18'h50, 0); ld("R2", 1, 4'b1010, 18'h50, 0);
        nop("R2", 2); ld("R2", 1, 4'hF, 18'h51, 0); nop("R2", 2);
        ld("R2", 0, 4'h0, 18'h50, 0); nop("R2", 3);

        // R6: each chip enable alone blocks a write
        ld("R6", 1, 4'hF, 18'h60, 0);
        step("R6", 0, 1, 0, 1, 0, 0, 4'hF, 18'h60);
        step("R6", 0, 1, 1, 0, 0, 0, 4'hF, 18'h60);
        step("R6", 0, 1, 1, 1, 1, 0, 4'hF, 18'h60);
        adv("R6", 1, 4'hF);
        ld("R6", 0, 4'h0, 18'h60, 0); nop("R6", 3);

        // R4 / R5: fill a block, then read in both orders
        for (int i = 0; i < 4; i++) ld("R4", 1, 4'hF, 18'h20 + AW'(i), 0);
        nop("R4", 2);
        ld("R4", 0, 4'h0, 18'h22, 0); adv("R4", 0, 4'h0); adv("R4", 0, 4'h0); adv("R4", 0, 4'h0);
        nop("R4", 3);
        ld("R5", 0, 4'h0, 18'h21, 1); adv("R5", 1, 4'hF); adv("R5", 1, 4'hF); adv("R5", 1, 4'hF);
        nop("R5", 3);

        // R10: write burst, advances carry conflicting we/lane_we
        ld("R10", 1, 4'hF, 18'h32, 0); adv("R10", 0, 4'h0); adv("R10", 0, 4'h1); adv("R10", 0, 4'h0);
        nop("R10", 2);
        ld("R10", 0, 4'h0, 18'h30, 1); adv("R10", 1, 4'hF); adv("R10", 0, 4'h0); adv("R10", 0, 4'h0);
        nop("R10", 3);

        // R7: stall in mid-pipeline with a junk write on the pins
        ld("R7", 1, 4'hF, 18'h70, 0); ld("R7", 0, 4'h0, 18'h20, 0);
        stall(3);
        ld("R7", 0, 4'h0, 18'h70, 0); nop("R7", 4);

        done = 1;
        summary();
        $finish;
    end

endmodule